// File: doc/BRIEF.md
# Clock Output State Controller

This block decides, for every clock output of a clock generator, which of four states the output driver takes: running, held low, high impedance, or a divided reference clock used for test. The controller does not make any clocks. It combines five kinds of input: a combined power-good/power-down pin, a test-select strap that is captured once at power-up, a real-time test-mode pin, two software test bits, and one software enable bit per output. It produces a two-bit mode per output that the output driver stages decode.

The combined pin works in two phases. While it has never been low, the device has not started. Its first low level captures the strap and starts the device. After that, a high level on the same pin means power-down. Test mode can be entered from the strap or from software. Once entered, it stays in force until a full reset. Each output accepts a new mode only while its own clock is low, so that stopping or restarting an output cannot cut a pulse short.

Top module: `clkout_state_ctrl`

## Requirements
- R1: Mode codes are 0 = running, 1 = driven low, 2 = high impedance, 3 = reference-divided test clock. Before the first low on the power pin, outputs flagged in STRAP_MASK read 2 and all other outputs read 1. This also holds out of reset.
- R2: The first low on the power pin, seen after the input synchronizer, starts the device. Every enabled output then runs (code 0), and the started state does not clear until reset.
- R3: After start, a high on the power pin puts every output at code 1. This overrides test mode and the enable bits. A low on the pin restores the previous behaviour.
- R4: The test-select strap is captured only at the first power-good event. Later changes of the strap pin, including changes across power-down cycles, have no effect.
- R5: With the strap captured high, test mode is active. The test-mode pin then selects code 2 when 0 and code 3 when 1, and the software reference-select bit at 1 forces code 3.
- R6: With the strap captured low, setting the software test-enable bit enters test mode. The software reference-select bit then picks code 2 (0) or code 3 (1), and the test-mode pin has no effect.
- R7: Once entered, test mode stays in force when the software test-enable bit is cleared. Only reset leaves it.
- R8: Outside test mode and power-down, a 0 in outEn[i] puts output i at code 1 and leaves the other outputs running.
- R9: The mode of output i changes only on a clock edge where phaseLow[i] is 1. Otherwise it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low full reset (power cycle) |
| pwrPin | input | 1 | Combined pin: first low = power good, later high = power-down |
| testSelPin | input | 1 | Test-select strap, captured once |
| testModePin | input | 1 | Real-time test type pin (0 = high-Z, 1 = reference clock) |
| swTestEn | input | 1 | Software test-mode entry bit |
| swRefSel | input | 1 | Software test type bit |
| outEn | input | NUM_OUT | Per-output enable bits |
| phaseLow | input | NUM_OUT | Per-output flag: that output's clock is currently low |
| modeOut | output | 2*NUM_OUT | Packed two-bit mode per output, output i at bits [2i+1:2i] |

## Verification
The bench builds the block with NUM_OUT = 4, STRAP_MASK = 4'b1100 and SYNC_STAGES = 2. These values give the bench outputs of both pre-start kinds (high impedance and low), so one run covers both R1 cases. They also let it gate a single output's phase while its neighbours keep updating. With only two synchronizer stages, every pin change settles within a few cycles. This leaves room to run both test entry paths, power-down over test mode, and the strap-ignore sequence across a full power-down cycle, each after its own reset.

// File: rtl/cosc_pkg.sv
package cosc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_LOW  = 2'd1,
    MODE_HIZ  = 2'd2,
    MODE_REFN = 2'd3
  } mode_e;

  // strobes from control to the per-output datapath
  typedef struct packed {
    logic started;
    logic powerDown;
    logic testActive;
    logic testRefN;
  } ctl_t;

endpackage

// File: rtl/cosc_ctrl.sv
module cosc_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwrPin,
  input  logic            testSelPin,
  input  logic            testModePin,
  input  logic            swTestEn,
  input  logic            swRefSel,
  output cosc_pkg::ctl_t  ctl
);
  localparam int LAST = SYNC_STAGES - 1;

  // synchronizer chains: pwr resets high (not yet power-good)
  logic [LAST:0] pwrSync, selSync, tmSync;
  logic started, strapQ, testLatched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrSync <= '1;
      selSync <= '0;
      tmSync  <= '0;
    end else begin
      pwrSync[0] <= pwrPin;
      selSync[0] <= testSelPin;
      tmSync[0]  <= testModePin;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        pwrSync[k] <= pwrSync[k-1];
        selSync[k] <= selSync[k-1];
        tmSync[k]  <= tmSync[k-1];
      end
    end
  end

  // one-time start and strap capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      strapQ  <= 1'b0;
    end else if (!started && !pwrSync[LAST]) begin
      started <= 1'b1;
      strapQ  <= selSync[LAST];
    end
  end

  // sticky test-mode entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      testLatched <= 1'b0;
    else if (started && (strapQ || swTestEn))
      testLatched <= 1'b1;
  end

  always_comb begin
    ctl.started    = started;
    ctl.powerDown  = started && pwrSync[LAST];
    ctl.testActive = testLatched;
    ctl.testRefN   = strapQ ? (tmSync[LAST] || swRefSel) : swRefSel;
  end

  assert_started_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    started |=> started);

  assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    started |=> $stable(strapQ));

  assert_test_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    testLatched |=> testLatched);

  assert_test_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    !started |=> !testLatched);

endmodule

// File: rtl/cosc_datapath.sv
module cosc_datapath #(
  parameter int                NUM_OUT    = 8,
  parameter logic [NUM_OUT-1:0] STRAP_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cosc_pkg::ctl_t       ctl,
  input  logic [NUM_OUT-1:0]   outEn,
  input  logic [NUM_OUT-1:0]   phaseLow,
  output logic [2*NUM_OUT-1:0] modeOut
);
  import cosc_pkg::*;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam mode_e IDLE_MODE = STRAP_MASK[i] ? MODE_HIZ : MODE_LOW;
    mode_e tgtMode, modeQ;

    always_comb begin
      if (!ctl.started)         tgtMode = IDLE_MODE;
      else if (ctl.powerDown)   tgtMode = MODE_LOW;
      else if (ctl.testActive)  tgtMode = ctl.testRefN ? MODE_REFN : MODE_HIZ;
      else if (!outEn[i])       tgtMode = MODE_LOW;
      else                      tgtMode = MODE_RUN;
    end

    // switch only while this output's clock is low
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            modeQ <= IDLE_MODE;
      else if (phaseLow[i]) modeQ <= tgtMode;
    end

    assign modeOut[2*i +: 2] = modeQ;

    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      !phaseLow[i] |=> $stable(modeQ));

    assert_pd_low_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.powerDown && phaseLow[i]) |=> (modeQ == MODE_LOW));

    assert_idle_not_run_R1: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.started |=> (modeQ != MODE_RUN && modeQ != MODE_REFN));
  end

endmodule

// File: rtl/clkout_state_ctrl.sv
module clkout_state_ctrl #(
  parameter int                NUM_OUT     = 8,
  parameter logic [NUM_OUT-1:0] STRAP_MASK  = 8'hC0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrPin,
  input  logic                 testSelPin,
  input  logic                 testModePin,
  input  logic                 swTestEn,
  input  logic                 swRefSel,
  input  logic [NUM_OUT-1:0]   outEn,
  input  logic [NUM_OUT-1:0]   phaseLow,
  output logic [2*NUM_OUT-1:0] modeOut
);
  cosc_pkg::ctl_t ctl;

  cosc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrPin(pwrPin), .testSelPin(testSelPin),
    .testModePin(testModePin), .swTestEn(swTestEn), .swRefSel(swRefSel),
    .ctl(ctl)
  );

  cosc_datapath #(.NUM_OUT(NUM_OUT), .STRAP_MASK(STRAP_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .outEn(outEn),
    .phaseLow(phaseLow), .modeOut(modeOut)
  );

endmodule

// File: tb/clkout_state_ctrl_tb.sv
module clkout_state_ctrl_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN, pwrPin, testSelPin, testModePin, swTestEn, swRefSel;
  logic [N-1:0]   outEn, phaseLow;
  logic [2*N-1:0] modeOut;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  clkout_state_ctrl #(.NUM_OUT(N), .STRAP_MASK(4'b1100), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .pwrPin(pwrPin), .testSelPin(testSelPin),
    .testModePin(testModePin), .swTestEn(swTestEn), .swRefSel(swRefSel),
    .outEn(outEn), .phaseLow(phaseLow), .modeOut(modeOut)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOut(input int idx, input logic [1:0] exp, input string tag);
    logic [1:0] act;
    act = modeOut[2*idx +: 2];
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s out%0d actual=%0d expected=%0d", tag, idx, act, exp);
    end
  endtask

  task automatic checkAll(input logic [1:0] exp, input string tag);
    for (int i = 0; i < N; i++) checkOut(i, exp, tag);
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; pwrPin = 1'b1; testSelPin = strap; testModePin = 1'b0;
    swTestEn = 1'b0; swRefSel = 1'b0; outEn = '1; phaseLow = '1;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic powerGood();
    pwrPin = 1'b0;
    waitCyc(6);
  endtask

  task automatic testPreStart();
    doReset(1'b0);
    waitCyc(5);
    checkOut(0, 2'd1, "R1"); checkOut(1, 2'd1, "R1");
    checkOut(2, 2'd2, "R1"); checkOut(3, 2'd2, "R1");
  endtask

  task automatic testStart();
    powerGood();
    checkAll(2'd0, "R2");
  endtask

  task automatic testEnables();
    outEn = 4'b1011;
    waitCyc(2);
    checkOut(2, 2'd1, "R8"); checkOut(0, 2'd0, "R8"); checkOut(3, 2'd0, "R8");
    outEn = '1;
    waitCyc(2);
    checkOut(2, 2'd0, "R8");
  endtask

  task automatic testPhaseGate();
    phaseLow = 4'b1110;
    outEn = 4'b1100;
    waitCyc(4);
    checkOut(0, 2'd0, "R9");
    checkOut(1, 2'd1, "R9");
    phaseLow = '1;
    waitCyc(2);
    checkOut(0, 2'd1, "R9");
    outEn = '1;
    waitCyc(2);
  endtask

  task automatic testPowerDown();
    pwrPin = 1'b1;
    waitCyc(6);
    checkAll(2'd1, "R3");
    pwrPin = 1'b0;
    waitCyc(6);
    checkAll(2'd0, "R3");
  endtask

  task automatic testStrapIgnored();
    testSelPin = 1'b1;
    testModePin = 1'b1;
    pwrPin = 1'b1;
    waitCyc(6);
    pwrPin = 1'b0;
    waitCyc(6);
    checkAll(2'd0, "R4");
    testSelPin = 1'b0;
    testModePin = 1'b0;
  endtask

  task automatic testSwEntry();
    swTestEn = 1'b1;
    waitCyc(3);
    checkAll(2'd2, "R6");
    testModePin = 1'b1;
    waitCyc(5);
    checkAll(2'd2, "R6");
    swRefSel = 1'b1;
    waitCyc(3);
    checkAll(2'd3, "R6");
    swTestEn = 1'b0;
    waitCyc(4);
    checkAll(2'd3, "R7");
  endtask

  task automatic testHwEntry();
    doReset(1'b1);
    powerGood();
    checkAll(2'd2, "R5");
    testModePin = 1'b1;
    waitCyc(5);
    checkAll(2'd3, "R5");
    testModePin = 1'b0;
    swRefSel = 1'b1;
    waitCyc(5);
    checkAll(2'd3, "R5");
    pwrPin = 1'b1;
    waitCyc(6);
    checkAll(2'd1, "R3");
  endtask

  task automatic testResetExit();
    doReset(1'b0);
    powerGood();
    checkAll(2'd0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testPreStart();
    testStart();
    testEnables();
    testPhaseGate();
    testPowerDown();
    testStrapIgnored();
    testSwEntry();
    testHwEntry();
    testResetExit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule